// File: doc/BRIEF.md
# Prioritized Backplane Bus Arbiter

This block is the single arbiter for a shared backplane on which masters compete for bus ownership at four priority levels. Each level has one active-low request input and one active-low grant output. The grant output drives the first link of a daisy chain that runs through all masters on that level. The arbiter also watches an active-low bus-busy line, which the current owner holds while it uses the bus. It drives an active-low bus-clear line that tells the owner to leave.

When the bus is free, the arbiter grants the highest pending level at once. When the bus is owned and a level above the owner's level starts requesting, the arbiter asserts bus-clear. It then waits for busy to go inactive and grants the highest level still pending. It drops bus-clear one cycle after that grant appears. A master that owns the bus keeps it for as long as it likes, unless a higher level asks for it. All asynchronous inputs pass through two-flop synchronizers before any decision uses them.

Top module: `bus_level_arbiter`

## Requirements
- R1: Request bit i (active low) belongs to level i. Level 3 ranks highest and level 0 lowest. When the bus is free, the grant goes to the highest level with a request.
- R2: A grant is never asserted while the synchronized busy line shows the bus as owned.
- R3: At most one grant output is low at any time.
- R4: Bus-clear is asserted when the bus is owned by a known level and a strictly higher level requests.
- R5: Bus-clear is not asserted for requests at or below the owner's level, or while the owner's level is unknown (the bus became busy without a grant from this arbiter).
- R6: When busy goes inactive during a clear, the grant for the highest pending level is asserted while bus-clear is still low. Bus-clear goes high on the next cycle.
- R7: A grant stays low until busy is seen active, or until that level withdraws its request. The arbiter then releases the grant and arbitrates again. When busy is seen active, the granted level becomes the recorded owner.
- R8: Once asserted, bus-clear stays low until busy goes inactive, even if the request that caused it is withdrawn.
- R9: A change on a request or busy input takes effect at the outputs at the third rising clock edge after it.
- R10: In reset, and right after it, all grant outputs and bus-clear are high (inactive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n | input | 4 | Active-low request, one bit per level |
| bus_busy_n | input | 1 | Active-low bus-busy from the owner |
| grant_n | output | 4 | Active-low grant to the first daisy-chain link of each level |
| bus_clear_n | output | 1 | Active-low request for the owner to release the bus |

## Verification
A wrong recorded owner level shows up as a clear that is missing, or a clear that is not needed. This appears at bus_clear_n three edges after the higher request arrives. A wrong state or a stale grant level makes a grant appear while busy is active, or on the wrong level, or two grants at once. These can be seen on the edge where the state changes. The tests follow each vector until the outputs settle. They also sample the clear-to-grant handover one edge at a time, so an early clear release or a late grant cannot be missed.

// File: rtl/bus_level_arbiter.sv
module bus_level_arbiter #(
  parameter int LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] bus_req_n,
  input  logic              bus_busy_n,
  output logic [LEVELS-1:0] grant_n,
  output logic              bus_clear_n
);
  localparam int LW = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_GRANT, ST_CLEAR} st_t;

  logic [LEVELS-1:0] req_m, req_s;
  logic              busy_m, busy_s;
  logic [LW-1:0]     top_lvl, gnt_lvl, own_lvl;
  logic              any_req, own_vld, clr;
  logic [LEVELS-1:0] gnt_vec;
  st_t               state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_m  <= '0;
      req_s  <= '0;
      busy_m <= 1'b0;
      busy_s <= 1'b0;
    end else begin
      req_m  <= ~bus_req_n;
      req_s  <= req_m;
      busy_m <= ~bus_busy_n;
      busy_s <= busy_m;
    end
  end

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < LEVELS; i++)
      if (req_s[i]) top_lvl = LW'(i);
  end
  assign any_req = |req_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      gnt_lvl <= '0;
      own_lvl <= '0;
      own_vld <= 1'b0;
      clr     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!busy_s) begin
            own_vld <= 1'b0;
            if (any_req) begin
              state   <= ST_GRANT;
              gnt_lvl <= top_lvl;
            end
          end else if (any_req && own_vld && top_lvl > own_lvl) begin
            state <= ST_CLEAR;
            clr   <= 1'b1;
          end
        end
        ST_GRANT: begin
          clr <= 1'b0;
          if (busy_s) begin
            own_lvl <= gnt_lvl;
            own_vld <= 1'b1;
            state   <= ST_IDLE;
          end else if (!req_s[gnt_lvl]) begin
            state <= ST_IDLE;
          end
        end
        ST_CLEAR: begin
          if (!busy_s) begin
            if (any_req) begin
              state   <= ST_GRANT;
              gnt_lvl <= top_lvl;
            end else begin
              state <= ST_IDLE;
              clr   <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    gnt_vec = '0;
    if (state == ST_GRANT) gnt_vec[gnt_lvl] = 1'b1;
  end

  assign grant_n     = ~gnt_vec;
  assign bus_clear_n = ~clr;

  p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grant_n));

  p_grant_when_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_vec) && !$past(|gnt_vec)) |-> !$past(busy_s));

  p_clear_needs_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr) |-> ($past(busy_s) && $past(own_vld)));

  p_handover_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_vec) && !$past(|gnt_vec) && $past(clr)) |-> clr);

  p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_vec) && !busy_s && (|(req_s & gnt_vec))) |=> (gnt_vec == $past(gnt_vec)));

  p_clear_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLEAR && busy_s) |=> clr);

endmodule

// File: tb/sim_bus_level_arbiter.sv
module sim_bus_level_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_req_n = 4'hF;
  logic       bus_busy_n = 1'b1;
  logic [3:0] grant_n;
  logic       bus_clear_n;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_level_arbiter #(.LEVELS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .bus_busy_n(bus_busy_n),
    .grant_n(grant_n), .bus_clear_n(bus_clear_n)
  );

  // {req_n, busy_n, expected grant_n, expected clear_n, requirement}
  localparam int NV = 18;
  localparam logic [13:0] VEC [NV] = '{
    {4'b1111, 1'b1, 4'b1111, 1'b1, 4'd10}, // R10 idle
    {4'b1101, 1'b1, 4'b1101, 1'b1, 4'd1},  // R1 free bus, level 1
    {4'b1101, 1'b0, 4'b1111, 1'b1, 4'd7},  // R7 busy taken, owner 1
    {4'b1100, 1'b0, 4'b1111, 1'b1, 4'd5},  // R5 lower request
    {4'b0100, 1'b0, 4'b1111, 1'b0, 4'd4},  // R4 level 3 preempts
    {4'b0100, 1'b1, 4'b0111, 1'b1, 4'd6},  // R6 handover to 3
    {4'b0100, 1'b0, 4'b1111, 1'b1, 4'd7},  // R7 owner 3
    {4'b1000, 1'b0, 4'b1111, 1'b1, 4'd5},  // R5 all lower than owner
    {4'b1000, 1'b1, 4'b1011, 1'b1, 4'd1},  // R1 level 2 wins
    {4'b1100, 1'b1, 4'b1101, 1'b1, 4'd7},  // R7 withdraw, re-arbitrate
    {4'b1111, 1'b1, 4'b1111, 1'b1, 4'd7},  // R7 withdraw all
    {4'b1110, 1'b0, 4'b1111, 1'b1, 4'd2},  // R2 unknown owner busy
    {4'b1110, 1'b1, 4'b1110, 1'b1, 4'd1},  // R1 level 0 granted
    {4'b1110, 1'b0, 4'b1111, 1'b1, 4'd7},  // R7 owner 0
    {4'b1010, 1'b0, 4'b1111, 1'b0, 4'd4},  // R4 level 2 preempts
    {4'b1110, 1'b0, 4'b1111, 1'b0, 4'd8},  // R8 clear kept after withdraw
    {4'b1110, 1'b1, 4'b1110, 1'b1, 4'd6},  // R6 remaining level 0
    {4'b1111, 1'b1, 4'b1111, 1'b1, 4'd7}   // R7 released
  };

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input int rq, input logic [3:0] eg, input logic ec);
    compared++;
    if (grant_n !== eg || bus_clear_n !== ec) begin
      mismatched++;
      $display("FAIL R%0d: grant_n=%b clear_n=%b expected grant_n=%b clear_n=%b",
               rq, grant_n, bus_clear_n, eg, ec);
    end
    compared++;
    if ($countones(~grant_n) > 1) begin
      mismatched++;
      $display("FAIL R3: grant_n=%b expected at most one low", grant_n);
    end
  endtask

  initial begin
    edges(2);
    check(10, 4'b1111, 1'b1); // R10 during reset
    rst_n = 1'b1;
    edges(2);
    check(10, 4'b1111, 1'b1); // R10 after reset
    for (int i = 0; i < NV; i++) begin
      bus_req_n  = VEC[i][13:10];
      bus_busy_n = VEC[i][9];
      edges(5);
      check(int'(VEC[i][3:0]), VEC[i][8:5], VEC[i][4]);
    end
    // R9 / R6: edge-exact handover
    bus_req_n = 4'b1110; bus_busy_n = 1'b1; edges(5);
    bus_busy_n = 1'b0; edges(5);
    bus_req_n = 4'b1010; edges(5);
    check(4, 4'b1111, 1'b0);
    bus_busy_n = 1'b1;
    edges(2);
    check(9, 4'b1111, 1'b0);  // R9 not yet visible
    edges(1);
    check(6, 4'b1011, 1'b0);  // R6 grant while clear still low
    edges(1);
    check(6, 4'b1011, 1'b1);  // R6 clear released next cycle
    // R10: reset while granted
    rst_n = 1'b0;
    #1;
    check(10, 4'b1111, 1'b1);
    bus_req_n = 4'hF;
    edges(1);
    rst_n = 1'b1;
    edges(3);
    check(10, 4'b1111, 1'b1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule